// File: doc/BRIEF.md
# Twin-Predicated Vector Element Sequencer

This block walks through the element loop of one vector instruction whose source side and destination side each have their own predicate mask. It keeps a source step and a destination step. Each step moves forward on its own, past the disabled elements of its own side. When both steps rest on enabled elements, the block issues one element operation. That operation carries a source register index, a destination register index, a write strobe and the result. One pass therefore compresses the enabled source elements and expands them into the enabled destination slots.

A start pulse loads the vector length, the two starting steps, the two register bases and the two mask descriptors. The masks are evaluated and latched at that moment. A mask is built from a general-purpose register value, its inverse, a one-hot decode of it, a condition-register bit, or is all ones. The block then issues at most one element operation per cycle and ends with a one-cycle done pulse. At the end it shows the final step values, which can be stored so that the loop resumes later. The only element operation is sign extension of the low byte. The register file sits outside the block: it returns the source operand combinationally for the index the block presents.

Top module: `twin_pred_seq`

## Requirements
- R1: After reset, and before any start, we_o and done_o are low and src_step_o and dst_step_o read zero.
- R2: An element whose source mask bit is zero is never read. A destination element whose mask bit is zero is never written, so its register keeps its old value.
- R3: The k-th operation pairs the k-th enabled source element at or after the start step with the k-th enabled destination element at or after the start step. The indices are src_idx_o = src_base + element and dst_idx_o = dst_base + element, taken modulo 32.
- R4: The loop stops as soon as either side has no enabled element left below VL. Any remaining enabled elements on the other side go unused. done_o pulses for one cycle, in the cycle after the last operation, and no operation occurs in that cycle. With VL=0 the block issues no operation and pulses done_o in the first cycle after the start.
- R5: The mode codes for each side are: 0 = every element enabled; 1 = mask is the GPR value; 2 = mask is the bitwise inverse of the GPR value; 3 = only element number GPR is enabled, or no element if the GPR value is 64 or more; 4 = condition-register mode. The codes 5 to 7 enable no element.
- R6: In condition-register mode, the mask bit of element i is cr_i[4*(4+i)+c], where c = crbit (0 lt, 1 gt, 2 eq, 3 so). Elements 4 and above are disabled. The source and destination sides may pick different values of c.
- R7: A start with non-zero srcstep_i or dststep_i resumes the loop. Elements below the starting step of a side are never used on that side.
- R8: wdata_o is the low byte of src_data_i, sign-extended to 64 bits.
- R9: When done_o is high, src_step_o and dst_step_o each hold one past the last element used on that side. A side that issued no operation shows its starting step.
- R10: A start_i that arrives while the loop runs is ignored. The masks are latched at the start, so later changes to the GPR or CR inputs do not affect the running loop.
- R11: Each operation moves both steps strictly upward, and every operation uses steps below VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a loop with the inputs below (ignored while running) |
| vl_i | input | 7 | Vector length, clamped to 64 |
| srcstep_i | input | 7 | Starting source step |
| dststep_i | input | 7 | Starting destination step |
| src_mode_i | input | 3 | Source mask mode code |
| dst_mode_i | input | 3 | Destination mask mode code |
| src_gpr_i | input | 64 | GPR value for the source mask |
| dst_gpr_i | input | 64 | GPR value for the destination mask |
| cr_i | input | 32 | Condition register, eight 4-bit fields |
| src_crbit_i | input | 2 | Condition bit tested for the source mask |
| dst_crbit_i | input | 2 | Condition bit tested for the destination mask |
| src_base_i | input | 5 | Source vector base register |
| dst_base_i | input | 5 | Destination vector base register |
| src_data_i | input | 64 | Register file read data at src_idx_o |
| we_o | output | 1 | Element operation issued this cycle |
| src_idx_o | output | 5 | Source register index |
| dst_idx_o | output | 5 | Destination register index |
| wdata_o | output | 64 | Sign-extended result |
| done_o | output | 1 | Loop finished (one-cycle pulse) |
| src_step_o | output | 7 | Current or final source step |
| dst_step_o | output | 7 | Current or final destination step |

## Verification
The hardest situation to bring about is a start that lands in the middle of a running loop, together with GPR inputs that change after the masks have been latched. The bench drives a long all-enabled loop. In the second busy cycle it raises start_i with VL=0 and clears the source GPR, then checks that all eight element writes still land and that the final steps are unchanged. Resumption is reached by loading non-zero starting steps directly, in both GPR mode and condition-register mode. Those two runs use disjoint source and destination masks, so only one element pair can meet.

// File: rtl/twin_pred_pkg.sv
package twin_pred_pkg;
  typedef enum logic [2:0] {
    MASK_ALL     = 3'd0,
    MASK_GPR     = 3'd1,
    MASK_GPR_INV = 3'd2,
    MASK_ONEHOT  = 3'd3,
    MASK_CR      = 3'd4
  } mask_mode_e;

  localparam int unsigned CR_FLD_W  = 4;
  localparam int unsigned CR_FIRST  = 4;
endpackage

// File: rtl/twin_pred_mask.sv
module twin_pred_mask
  import twin_pred_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned MAX_VL = 64,
  parameter int unsigned CR_W   = 32
) (
  input  logic [2:0]        mode_i,
  input  logic [XLEN-1:0]   gpr_i,
  input  logic [CR_W-1:0]   cr_i,
  input  logic [1:0]        crbit_i,
  output logic [MAX_VL-1:0] mask_o
);
  localparam int unsigned N_FLD = CR_W / CR_FLD_W;
  localparam int unsigned N_CR  = (N_FLD > CR_FIRST) ? N_FLD - CR_FIRST : 0;
  localparam int unsigned IDX_W = $clog2(MAX_VL);

  logic [MAX_VL-1:0] cr_mask;
  logic [MAX_VL-1:0] oh_mask;

  for (genvar i = 0; i < MAX_VL; i++) begin : g_cr
    if (i < N_CR) begin : g_fld
      logic [CR_FLD_W-1:0] fld;
      assign fld        = cr_i[(CR_FIRST+i)*CR_FLD_W +: CR_FLD_W];
      assign cr_mask[i] = fld[crbit_i];
    end else begin : g_none
      assign cr_mask[i] = 1'b0;
    end
  end

  always_comb begin
    oh_mask = '0;
    if (gpr_i < XLEN'(MAX_VL)) oh_mask[gpr_i[IDX_W-1:0]] = 1'b1;
  end

  always_comb begin
    unique case (mode_i)
      MASK_ALL:     mask_o = '1;
      MASK_GPR:     mask_o = MAX_VL'(gpr_i);
      MASK_GPR_INV: mask_o = ~MAX_VL'(gpr_i);
      MASK_ONEHOT:  mask_o = oh_mask;
      MASK_CR:      mask_o = cr_mask;
      default:      mask_o = '0;
    endcase
  end
endmodule

// File: rtl/twin_pred_find.sv
module twin_pred_find #(
  parameter int unsigned MAX_VL = 64,
  parameter int unsigned STEP_W = 7
) (
  input  logic [MAX_VL-1:0] mask_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [STEP_W-1:0] vl_i,
  output logic [STEP_W-1:0] pos_o,
  output logic              hit_o
);
  // lowest enabled element in [step, vl)
  always_comb begin
    hit_o = 1'b0;
    pos_o = '0;
    for (int i = MAX_VL - 1; i >= 0; i--) begin
      if (mask_i[i] && (STEP_W'(i) >= step_i) && (STEP_W'(i) < vl_i)) begin
        hit_o = 1'b1;
        pos_o = STEP_W'(i);
      end
    end
  end
endmodule

// File: rtl/twin_pred_seq.sv
module twin_pred_seq
  import twin_pred_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned MAX_VL = 64,
  parameter int unsigned STEP_W = 7,
  parameter int unsigned REG_W  = 5,
  parameter int unsigned CR_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [STEP_W-1:0] vl_i,
  input  logic [STEP_W-1:0] srcstep_i,
  input  logic [STEP_W-1:0] dststep_i,
  input  logic [2:0]        src_mode_i,
  input  logic [2:0]        dst_mode_i,
  input  logic [XLEN-1:0]   src_gpr_i,
  input  logic [XLEN-1:0]   dst_gpr_i,
  input  logic [CR_W-1:0]   cr_i,
  input  logic [1:0]        src_crbit_i,
  input  logic [1:0]        dst_crbit_i,
  input  logic [REG_W-1:0]  src_base_i,
  input  logic [REG_W-1:0]  dst_base_i,
  input  logic [XLEN-1:0]   src_data_i,
  output logic              we_o,
  output logic [REG_W-1:0]  src_idx_o,
  output logic [REG_W-1:0]  dst_idx_o,
  output logic [XLEN-1:0]   wdata_o,
  output logic              done_o,
  output logic [STEP_W-1:0] src_step_o,
  output logic [STEP_W-1:0] dst_step_o
);
  localparam logic [STEP_W-1:0] VL_CAP = STEP_W'(MAX_VL);
  localparam int unsigned       BYTE_W = 8;

  logic              busy_q;
  logic [STEP_W-1:0] vl_q, ss_q, ds_q;
  logic [MAX_VL-1:0] smask_q, dmask_q;
  logic [REG_W-1:0]  sbase_q, dbase_q;

  logic [MAX_VL-1:0] smask_d, dmask_d;
  logic [STEP_W-1:0] s_pos, d_pos;
  logic              s_hit, d_hit, fire, load;

  twin_pred_mask #(.XLEN(XLEN), .MAX_VL(MAX_VL), .CR_W(CR_W)) u_smask (
    .mode_i(src_mode_i), .gpr_i(src_gpr_i), .cr_i(cr_i),
    .crbit_i(src_crbit_i), .mask_o(smask_d)
  );

  twin_pred_mask #(.XLEN(XLEN), .MAX_VL(MAX_VL), .CR_W(CR_W)) u_dmask (
    .mode_i(dst_mode_i), .gpr_i(dst_gpr_i), .cr_i(cr_i),
    .crbit_i(dst_crbit_i), .mask_o(dmask_d)
  );

  twin_pred_find #(.MAX_VL(MAX_VL), .STEP_W(STEP_W)) u_sfind (
    .mask_i(smask_q), .step_i(ss_q), .vl_i(vl_q), .pos_o(s_pos), .hit_o(s_hit)
  );

  twin_pred_find #(.MAX_VL(MAX_VL), .STEP_W(STEP_W)) u_dfind (
    .mask_i(dmask_q), .step_i(ds_q), .vl_i(vl_q), .pos_o(d_pos), .hit_o(d_hit)
  );

  assign load   = start_i & ~busy_q;
  assign fire   = busy_q & s_hit & d_hit;
  assign done_o = busy_q & ~fire;

  assign we_o       = fire;
  assign src_idx_o  = sbase_q + REG_W'(s_pos);
  assign dst_idx_o  = dbase_q + REG_W'(d_pos);
  assign wdata_o    = {{(XLEN-BYTE_W){src_data_i[BYTE_W-1]}}, src_data_i[BYTE_W-1:0]};
  assign src_step_o = ss_q;
  assign dst_step_o = ds_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      vl_q    <= '0;
      ss_q    <= '0;
      ds_q    <= '0;
      smask_q <= '0;
      dmask_q <= '0;
      sbase_q <= '0;
      dbase_q <= '0;
    end else if (load) begin
      busy_q  <= 1'b1;
      vl_q    <= (vl_i > VL_CAP) ? VL_CAP : vl_i;
      ss_q    <= srcstep_i;
      ds_q    <= dststep_i;
      smask_q <= smask_d;
      dmask_q <= dmask_d;
      sbase_q <= src_base_i;
      dbase_q <= dst_base_i;
    end else if (fire) begin
      ss_q <= s_pos + 1'b1;
      ds_q <= d_pos + 1'b1;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/twin_pred_seq_chk.sv
module twin_pred_seq_chk #(
  parameter int unsigned STEP_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              we_o,
  input logic              done_o,
  input logic              busy_q,
  input logic [STEP_W-1:0] vl_q,
  input logic [STEP_W-1:0] src_step_o,
  input logic [STEP_W-1:0] dst_step_o
);
  // R4
  we_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_o && done_o));

  // R4
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !we_o));

  // R11
  src_step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> (src_step_o > $past(src_step_o)));

  // R11
  dst_step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> (dst_step_o > $past(dst_step_o)));

  // R11
  step_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (src_step_o < vl_q && dst_step_o < vl_q));

  // R10
  restart_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> $stable(vl_q));
endmodule

bind twin_pred_seq twin_pred_seq_chk #(.STEP_W(STEP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .we_o(we_o),
  .done_o(done_o), .busy_q(busy_q), .vl_q(vl_q),
  .src_step_o(src_step_o), .dst_step_o(dst_step_o)
);

// File: tb/twin_pred_seq_bench.sv
`timescale 1ns/1ps
module twin_pred_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [6:0]  vl_i = '0, srcstep_i = '0, dststep_i = '0;
  logic [2:0]  src_mode_i = '0, dst_mode_i = '0;
  logic [63:0] src_gpr_i = '0, dst_gpr_i = '0;
  logic [31:0] cr_i = '0;
  logic [1:0]  src_crbit_i = '0, dst_crbit_i = '0;
  logic [4:0]  src_base_i = '0, dst_base_i = '0;
  logic [63:0] src_data_i;
  logic        we_o, done_o;
  logic [4:0]  src_idx_o, dst_idx_o;
  logic [63:0] wdata_o;
  logic [6:0]  src_step_o, dst_step_o;

  int n_chk = 0, n_fail = 0;
  logic [63:0] rf [32];
  logic [63:0] exp_rf [32];

  always #2 clk = ~clk;

  twin_pred_seq u_twin_pred_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .vl_i(vl_i),
    .srcstep_i(srcstep_i), .dststep_i(dststep_i),
    .src_mode_i(src_mode_i), .dst_mode_i(dst_mode_i),
    .src_gpr_i(src_gpr_i), .dst_gpr_i(dst_gpr_i), .cr_i(cr_i),
    .src_crbit_i(src_crbit_i), .dst_crbit_i(dst_crbit_i),
    .src_base_i(src_base_i), .dst_base_i(dst_base_i),
    .src_data_i(src_data_i), .we_o(we_o), .src_idx_o(src_idx_o),
    .dst_idx_o(dst_idx_o), .wdata_o(wdata_o), .done_o(done_o),
    .src_step_o(src_step_o), .dst_step_o(dst_step_o)
  );

  assign src_data_i = rf[src_idx_o];
  always @(posedge clk) if (we_o) rf[dst_idx_o] <= wdata_o;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R5, R6 encodings as stated in the requirements
  function automatic logic [63:0] ref_mask(input logic [2:0] m, input logic [63:0] g,
                                           input logic [31:0] cr, input logic [1:0] c);
    logic [63:0] r = '0;
    case (m)
      3'd0: r = '1;
      3'd1: r = g;
      3'd2: r = ~g;
      3'd3: if (g < 64) r[g[5:0]] = 1'b1;
      3'd4: for (int i = 0; i < 4; i++) r[i] = cr[4*(4+i)+c];
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [63:0] sext8(input logic [63:0] v);
    return {{56{v[7]}}, v[7:0]};
  endfunction

  task automatic init_rf();
    for (int i = 0; i < 32; i++) rf[i] = 64'hC0DE_0000_0000_0000 + 64'(i);
  endtask

  task automatic run_case(input string tag, input int vl, input int ss, input int ds,
                          input logic [2:0] sm, input logic [2:0] dm,
                          input logic [63:0] sg, input logic [63:0] dg,
                          input logic [31:0] cr, input logic [1:0] sc, input logic [1:0] dc,
                          input logic [4:0] sb, input logic [4:0] db, input bit poke);
    logic [63:0] smk, dmk;
    int s, d, sp, dp, ops, got_ops, cyc;
    bit seen_done;
    logic [4:0] wi;
    for (int i = 0; i < 32; i++) exp_rf[i] = rf[i];
    smk = ref_mask(sm, sg, cr, sc);
    dmk = ref_mask(dm, dg, cr, dc);
    s = ss; d = ds; ops = 0;
    for (int it = 0; it < 80; it++) begin
      sp = -1; dp = -1;
      for (int i = 63; i >= 0; i--) begin
        if (smk[i] && i >= s && i < vl) sp = i;
        if (dmk[i] && i >= d && i < vl) dp = i;
      end
      if (sp < 0 || dp < 0) break;
      wi = db + 5'(dp);
      exp_rf[wi] = sext8(exp_rf[5'(sb + 5'(sp))]);
      s = sp + 1; d = dp + 1; ops++;
    end

    vl_i = 7'(vl); srcstep_i = 7'(ss); dststep_i = 7'(ds);
    src_mode_i = sm; dst_mode_i = dm; src_gpr_i = sg; dst_gpr_i = dg;
    cr_i = cr; src_crbit_i = sc; dst_crbit_i = dc;
    src_base_i = sb; dst_base_i = db; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    got_ops = 0; seen_done = 0;
    for (cyc = 0; cyc < 300; cyc++) begin
      if (poke && cyc == 1) begin
        start_i = 1'b1; vl_i = '0; src_gpr_i = '0; src_mode_i = 3'd1;
      end else begin
        start_i = 1'b0;
      end
      if (we_o) got_ops++;
      if (done_o) begin
        seen_done = 1;
        check(src_step_o == 7'(s), {tag, " R9 src step"}, 64'(src_step_o), 64'(s));
        check(dst_step_o == 7'(d), {tag, " R9 dst step"}, 64'(dst_step_o), 64'(d));
        break;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    check(seen_done, {tag, " R4 done seen"}, 64'(seen_done), 64'd1);
    check(got_ops == ops, {tag, " R4 op count"}, 64'(got_ops), 64'(ops));
    @(negedge clk);
    check(!done_o && !we_o, {tag, " R4 done one pulse"}, {62'd0, done_o, we_o}, 64'd0);
    for (int i = 0; i < 32; i++)
      check(rf[i] === exp_rf[i], $sformatf("%s R2 R3 R8 reg %0d", tag, i), rf[i], exp_rf[i]);
  endtask

  // R2 R3 R5: inverted source 0b01, dest GPR 0b10
  task automatic t_twin_inv();
    init_rf(); rf[9] = 64'h91; rf[10] = 64'h90;
    run_case("twin_inv", 2, 0, 0, 3'd2, 3'd1, 64'b10, 64'b10, '0, 0, 0, 5'd9, 5'd5, 0);
    check(rf[6] == 64'hFFFF_FFFF_FFFF_FF91, "R8 sext 0x91", rf[6], 64'hFFFF_FFFF_FFFF_FF91);
  endtask

  // R4 R5: compress with all-enabled dest
  task automatic t_compress();
    init_rf(); rf[9] = 64'h90; rf[10] = 64'h91; rf[11] = 64'h92;
    run_case("compress", 3, 0, 0, 3'd1, 3'd0, 64'b101, 64'd0, '0, 0, 0, 5'd9, 5'd5, 0);
    check(rf[5] == 64'hFFFF_FFFF_FFFF_FF90, "R3 compress elem0", rf[5], 64'hFFFF_FFFF_FFFF_FF90);
    check(rf[6] == 64'hFFFF_FFFF_FFFF_FF92, "R3 compress elem1", rf[6], 64'hFFFF_FFFF_FFFF_FF92);
  endtask

  // R2 R4: expand into dest 0b101, src tail unused
  task automatic t_expand();
    init_rf(); rf[9] = 64'h90; rf[10] = 64'h91; rf[11] = 64'h92;
    run_case("expand", 3, 0, 0, 3'd0, 3'd1, 64'd0, 64'b101, '0, 0, 0, 5'd9, 5'd5, 0);
    check(rf[6] == 64'hC0DE_0000_0000_0006, "R2 masked dest kept", rf[6], 64'hC0DE_0000_0000_0006);
  endtask

  // R7: resume from srcstep=1, dststep=2
  task automatic t_resume();
    init_rf(); rf[9] = 64'h90; rf[10] = 64'h91; rf[11] = 64'h92; rf[12] = 64'h93;
    run_case("resume", 4, 1, 2, 3'd1, 3'd2, 64'b0101, 64'b0101, '0, 0, 0, 5'd9, 5'd5, 0);
    check(rf[8] == 64'hFFFF_FFFF_FFFF_FF92, "R7 resumed op", rf[8], 64'hFFFF_FFFF_FFFF_FF92);
  endtask

  // R5: one-hot dest, element 1
  task automatic t_onehot();
    init_rf(); rf[9] = 64'h90; rf[10] = 64'h91; rf[11] = 64'h92;
    run_case("onehot", 3, 0, 0, 3'd1, 3'd3, 64'b100, 64'd1, '0, 0, 0, 5'd9, 5'd5, 0);
    check(rf[6] == 64'hFFFF_FFFF_FFFF_FF92, "R5 onehot dest", rf[6], 64'hFFFF_FFFF_FFFF_FF92);
    init_rf();
    run_case("onehot_big", 3, 0, 0, 3'd3, 3'd0, 64'd70, 64'd0, '0, 0, 0, 5'd9, 5'd5, 0);
  endtask

  // R6 R7: CR masks, eq for source and lt for dest, resumed
  task automatic t_cr();
    logic [31:0] cr = '0;
    init_rf(); rf[9] = 64'h90; rf[10] = 64'h91; rf[11] = 64'h92; rf[12] = 64'h93;
    cr[4*4+2] = 1; cr[4*6+2] = 1;
    cr[4*5+0] = 1; cr[4*7+0] = 1;
    run_case("cr", 4, 1, 2, 3'd4, 3'd4, 64'd0, 64'd0, cr, 2'd2, 2'd0, 5'd9, 5'd5, 0);
    check(rf[8] == 64'hFFFF_FFFF_FFFF_FF92, "R6 cr op", rf[8], 64'hFFFF_FFFF_FFFF_FF92);
  endtask

  // R4: VL=0
  task automatic t_vl0();
    init_rf();
    run_case("vl0", 0, 0, 0, 3'd0, 3'd0, 64'd0, 64'd0, '0, 0, 0, 5'd0, 5'd16, 0);
  endtask

  // R10: restart mid-loop and GPR change after start are ignored
  task automatic t_restart();
    init_rf();
    for (int i = 0; i < 8; i++) rf[i] = 64'h80 + 64'(i * 3);
    run_case("restart", 8, 0, 0, 3'd1, 3'd0, 64'hFF, 64'd0, '0, 0, 0, 5'd0, 5'd20, 1);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    init_rf();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!we_o && !done_o, "R1 reset strobes", {62'd0, we_o, done_o}, 64'd0);
    check(src_step_o == 0 && dst_step_o == 0, "R1 reset steps",
          {50'd0, src_step_o, dst_step_o}, 64'd0);
    t_twin_inv();
    t_compress();
    t_expand();
    t_resume();
    t_onehot();
    t_cr();
    t_vl0();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule